// File: doc/BRIEF.md
# One-Shot Keyed Write Gate for Protected Registers

This block sits on a register write bus, in front of a bank of configuration registers. Some of those registers are marked as protected. A write to a protected register only goes through when the write just before it was an unlock command. That command must carry the correct key byte and name the offset of the protected register.

Writes that pass appear one cycle later on a registered write-enable, address and data output, which drives the register bank. The gate decodes two offsets for itself and never forwards them: the unlock register and the status register. A refused write is dropped and raises a sticky access-error flag. Software clears the flag through the status register.

The unlock is one-shot. It covers one offset only, and it is used up by the next bus write, whatever that write targets. Cycles with no write do not use it up.

Top module: `prot_write_gate`

## Requirements
- R1: After reset, `out_we` and `acc_err` are 0 and the gate is locked, so the first protected write is refused.
- R2: An unlock write is a write to offset 0x3F8 with data bits 31:24 equal to 0xAA and bits 9:0 holding a target offset. If the next write targets that protected offset, it appears on `out_we`/`out_addr`/`out_data` one cycle after it is captured, with the same address and data.
- R3: An unlock write whose bits 31:24 differ from 0xAA sets `acc_err` and leaves the gate locked.
- R4: A write to a protected register with no valid unlock before it produces no `out_we` pulse and sets `acc_err`.
- R5: A protected write to an offset other than the unlocked target is refused and sets `acc_err`.
- R6: The pending unlock is used up by the next bus write of any kind, including a passed write to an unprotected register.
- R7: Register i sits at byte offset 4*i, for i below 16, and is protected when bit i of the mask parameter is set (default 0xF0F0). Every other offset, except the two offsets the gate decodes, is unprotected. Unprotected writes always pass, one cycle later, and do not change `acc_err`.
- R8: `acc_err` stays set until a write to offset 0x3FC with data bit 0 equal to 1. A write there with bit 0 equal to 0 leaves the flag unchanged.
- R9: Writes to the unlock offset 0x3F8 and the status offset 0x3FC never appear on `out_we`.
- R10: Cycles without a bus write do not use up a pending unlock.
- R11: A second unlock write replaces the target of the first. Only the newest target is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | 10 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| out_we | output | 1 | Registered write enable toward the register bank |
| out_addr | output | 10 | Registered offset of the forwarded write |
| out_data | output | 32 | Registered data of the forwarded write |
| acc_err | output | 1 | Sticky access-error flag |

## Verification
The delicate cycle is the one where a refused write also uses up the unlock. A write to the wrong protected offset sets the error flag and disarms the gate in the same clock. The bench provokes this with an unlock for one offset followed by a write to a neighbouring protected offset. It then checks that no write-enable pulse appears, that the error flag rises, and that a follow-up write to the originally named offset is also refused. The same overlap is checked with a wrong-key unlock, which must raise the error and leave the gate locked at once.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
  localparam int KEY_W = 8;

  typedef enum logic [1:0] {
    WK_IDLE,
    WK_UNLOCK,
    WK_STATUS,
    WK_REG
  } wr_kind_e;
endpackage

// File: rtl/pwg_classify.sv
module pwg_classify
  import pwg_pkg::*;
#(
  parameter int                ADDR_W     = 10,
  parameter int                NUM_REGS   = 16,
  parameter logic [NUM_REGS-1:0] PROT_MASK = 16'hF0F0,
  parameter logic [ADDR_W-1:0] UNLOCK_OFS = 10'h3F8,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 10'h3FC
) (
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  output wr_kind_e          kind,
  output logic              is_prot
);
  logic [NUM_REGS-1:0] hit;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    assign hit[i] = (wr_addr == ADDR_W'(4 * i));
  end

  assign is_prot = |(hit & PROT_MASK);

  always_comb begin
    if (!wr_valid)                 kind = WK_IDLE;
    else if (wr_addr == UNLOCK_OFS) kind = WK_UNLOCK;
    else if (wr_addr == STATUS_OFS) kind = WK_STATUS;
    else                           kind = WK_REG;
  end
endmodule

// File: rtl/pwg_unlock.sv
module pwg_unlock
  import pwg_pkg::*;
#(
  parameter int               ADDR_W = 10,
  parameter logic [KEY_W-1:0] KEY    = 8'hAA
) (
  input  logic              clk,
  input  logic              rst,
  input  wr_kind_e          kind,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [KEY_W-1:0]  key_field,
  input  logic [ADDR_W-1:0] ofs_field,
  output logic              armed,
  output logic              grant,
  output logic              key_ok
);
  logic [ADDR_W-1:0] target;

  assign key_ok = (key_field == KEY);
  assign grant  = (kind == WK_REG) && armed && (target == wr_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      target <= '0;
    end else begin
      case (kind)
        WK_UNLOCK: begin
          armed <= key_ok;
          if (key_ok) target <= ofs_field;
        end
        WK_STATUS, WK_REG: armed <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pwg_err_flag.sv
module pwg_err_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic err
);
  always_ff @(posedge clk) begin
    if (rst)        err <= 1'b0;
    else if (set_i) err <= 1'b1;
    else if (clr_i) err <= 1'b0;
  end
endmodule

// File: rtl/prot_write_gate.sv
module prot_write_gate
  import pwg_pkg::*;
#(
  parameter int                  ADDR_W     = 10,
  parameter int                  DATA_W     = 32,
  parameter int                  NUM_REGS   = 16,
  parameter logic [NUM_REGS-1:0] PROT_MASK  = 16'hF0F0,
  parameter logic [ADDR_W-1:0]   UNLOCK_OFS = 10'h3F8,
  parameter logic [ADDR_W-1:0]   STATUS_OFS = 10'h3FC,
  parameter logic [KEY_W-1:0]    KEY        = 8'hAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              out_we,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              acc_err
);
  wr_kind_e kind;
  logic     is_prot;
  logic     grant;
  logic     key_ok;
  logic     unlock_armed;
  logic     pass;
  logic     err_set;
  logic     err_clr;

  pwg_classify #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .PROT_MASK(PROT_MASK),
    .UNLOCK_OFS(UNLOCK_OFS), .STATUS_OFS(STATUS_OFS)
  ) u_cls (
    .wr_valid(wr_valid),
    .wr_addr (wr_addr),
    .kind    (kind),
    .is_prot (is_prot)
  );

  pwg_unlock #(.ADDR_W(ADDR_W), .KEY(KEY)) u_unl (
    .clk      (clk),
    .rst      (rst),
    .kind     (kind),
    .wr_addr  (wr_addr),
    .key_field(wr_data[DATA_W-1 -: KEY_W]),
    .ofs_field(wr_data[ADDR_W-1:0]),
    .armed    (unlock_armed),
    .grant    (grant),
    .key_ok   (key_ok)
  );

  assign pass    = (kind == WK_REG) && (!is_prot || grant);
  assign err_set = ((kind == WK_REG) && is_prot && !grant) ||
                   ((kind == WK_UNLOCK) && !key_ok);
  assign err_clr = (kind == WK_STATUS) && wr_data[0];

  pwg_err_flag u_err (
    .clk  (clk),
    .rst  (rst),
    .set_i(err_set),
    .clr_i(err_clr),
    .err  (acc_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_we   <= 1'b0;
      out_addr <= '0;
      out_data <= '0;
    end else begin
      out_we <= pass;
      if (pass) begin
        out_addr <= wr_addr;
        out_data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/prot_write_gate_chk.sv
module prot_write_gate_chk #(
  parameter int                  ADDR_W     = 10,
  parameter int                  DATA_W     = 32,
  parameter int                  NUM_REGS   = 16,
  parameter logic [NUM_REGS-1:0] PROT_MASK  = 16'hF0F0,
  parameter logic [ADDR_W-1:0]   UNLOCK_OFS = 10'h3F8,
  parameter logic [ADDR_W-1:0]   STATUS_OFS = 10'h3FC
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              out_we,
  input logic [ADDR_W-1:0] out_addr,
  input logic [DATA_W-1:0] out_data,
  input logic              acc_err,
  input logic              unlock_armed
);
  function automatic logic prot_of(input logic [ADDR_W-1:0] a);
    logic r = 1'b0;
    for (int k = 0; k < NUM_REGS; k++)
      if (PROT_MASK[k] && a == ADDR_W'(4 * k)) r = 1'b1;
    return r;
  endfunction

  logic own_ofs;
  logic clr_wr;
  assign own_ofs = (wr_addr == UNLOCK_OFS) || (wr_addr == STATUS_OFS);
  assign clr_wr  = wr_valid && (wr_addr == STATUS_OFS) && wr_data[0];

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!out_we && !acc_err));

  p_copy_fwd_r2: assert property (@(posedge clk) disable iff (rst)
    out_we |-> (out_addr == $past(wr_addr) && out_data == $past(wr_data)));

  p_locked_refuse_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && prot_of(wr_addr) && !unlock_armed) |=> (!out_we && acc_err));

  p_unprot_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !own_ofs && !prot_of(wr_addr)) |=> out_we);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (acc_err && !clr_wr) |=> acc_err);

  p_err_clear_r8: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> !acc_err);

  p_own_hidden_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && own_ofs) |=> !out_we);

  p_idle_keeps_r10: assert property (@(posedge clk) disable iff (rst)
    (!wr_valid && unlock_armed) |=> unlock_armed);
endmodule

bind prot_write_gate prot_write_gate_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
  .PROT_MASK(PROT_MASK), .UNLOCK_OFS(UNLOCK_OFS), .STATUS_OFS(STATUS_OFS)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_valid    (wr_valid),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .out_we      (out_we),
  .out_addr    (out_addr),
  .out_data    (out_data),
  .acc_err     (acc_err),
  .unlock_armed(unlock_armed)
);

// File: tb/prot_write_gate_tb_top.sv
`timescale 1ns/100ps
module prot_write_gate_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic [9:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        out_we;
  logic [9:0]  out_addr;
  logic [31:0] out_data;
  logic        acc_err;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  localparam logic [9:0] UNL = 10'h3F8;
  localparam logic [9:0] STA = 10'h3FC;

  always #2.5 clk = ~clk;

  prot_write_gate dut_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .out_we(out_we), .out_addr(out_addr),
    .out_data(out_data), .acc_err(acc_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drives one write for one cycle; returns at the falling edge after capture,
  // where the registered outputs show the result of that write.
  task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  function automatic logic [31:0] unl_word(input logic [7:0] key, input logic [9:0] ofs);
    return {key, 14'b0, ofs};
  endfunction

  task automatic clear_err();
    bus_wr(STA, 32'h1);
  endtask

  task automatic t_reset();
    chk("R1 out_we after reset", {31'b0, out_we}, 32'd0);
    chk("R1 acc_err after reset", {31'b0, acc_err}, 32'd0);
    bus_wr(10'h010, 32'hDEAD0001);
    chk("R1 R4 locked write dropped", {31'b0, out_we}, 32'd0);
    chk("R4 error raised", {31'b0, acc_err}, 32'd1);
    clear_err();
    chk("R8 cleared by status write", {31'b0, acc_err}, 32'd0);
    chk("R9 status write hidden", {31'b0, out_we}, 32'd0);
  endtask

  task automatic t_unlock_pass();
    bus_wr(UNL, unl_word(8'hAA, 10'h014));
    chk("R9 unlock write hidden", {31'b0, out_we}, 32'd0);
    bus_wr(10'h014, 32'h12345678);
    chk("R2 target passes", {31'b0, out_we}, 32'd1);
    chk("R2 addr forwarded", {22'b0, out_addr}, 32'h014);
    chk("R2 data forwarded", out_data, 32'h12345678);
    chk("R2 no error", {31'b0, acc_err}, 32'd0);
  endtask

  task automatic t_bad_key();
    bus_wr(UNL, unl_word(8'h55, 10'h014));
    chk("R3 bad key error", {31'b0, acc_err}, 32'd1);
    clear_err();
    bus_wr(10'h014, 32'hAAAA0000);
    chk("R3 gate stayed locked", {31'b0, out_we}, 32'd0);
    chk("R3 refused write flags", {31'b0, acc_err}, 32'd1);
    clear_err();
  endtask

  task automatic t_wrong_target();
    bus_wr(UNL, unl_word(8'hAA, 10'h014));
    bus_wr(10'h018, 32'h0BAD0BAD);
    chk("R5 other offset refused", {31'b0, out_we}, 32'd0);
    chk("R5 error raised", {31'b0, acc_err}, 32'd1);
    clear_err();
    bus_wr(10'h014, 32'h0BAD0BAE);
    chk("R5 R6 unlock consumed by refused write", {31'b0, out_we}, 32'd0);
    clear_err();
  endtask

  task automatic t_expiry();
    bus_wr(UNL, unl_word(8'hAA, 10'h030));
    bus_wr(10'h004, 32'h00000044);
    chk("R6 R7 unprotected passes", {31'b0, out_we}, 32'd1);
    bus_wr(10'h030, 32'h00000030);
    chk("R6 expired unlock", {31'b0, out_we}, 32'd0);
    chk("R6 error raised", {31'b0, acc_err}, 32'd1);
    clear_err();
  endtask

  task automatic t_unprot();
    bus_wr(10'h008, 32'hCAFEF00D);
    chk("R7 pass", {31'b0, out_we}, 32'd1);
    chk("R7 data", out_data, 32'hCAFEF00D);
    chk("R7 no error", {31'b0, acc_err}, 32'd0);
    bus_wr(10'h200, 32'h00000200);
    chk("R7 out-of-bank offset passes", {31'b0, out_we}, 32'd1);
    chk("R7 out-of-bank addr", {22'b0, out_addr}, 32'h200);
  endtask

  task automatic t_sticky();
    bus_wr(10'h03C, 32'h1);
    chk("R8 error set", {31'b0, acc_err}, 32'd1);
    bus_wr(10'h00C, 32'h2);
    chk("R8 R7 kept across unprotected write", {31'b0, acc_err}, 32'd1);
    bus_wr(STA, 32'h0);
    chk("R8 zero write keeps flag", {31'b0, acc_err}, 32'd1);
    clear_err();
    chk("R8 one write clears flag", {31'b0, acc_err}, 32'd0);
  endtask

  task automatic t_idle();
    bus_wr(UNL, unl_word(8'hAA, 10'h01C));
    repeat (5) @(negedge clk);
    bus_wr(10'h01C, 32'h1C1C1C1C);
    chk("R10 unlock survives idle", {31'b0, out_we}, 32'd1);
    chk("R10 no error", {31'b0, acc_err}, 32'd0);
  endtask

  task automatic t_rearm();
    bus_wr(UNL, unl_word(8'hAA, 10'h010));
    bus_wr(UNL, unl_word(8'hAA, 10'h03C));
    bus_wr(10'h03C, 32'h3C3C3C3C);
    chk("R11 newest target passes", {31'b0, out_we}, 32'd1);
    bus_wr(UNL, unl_word(8'hAA, 10'h010));
    bus_wr(UNL, unl_word(8'hAA, 10'h03C));
    bus_wr(10'h010, 32'h10101010);
    chk("R11 older target refused", {31'b0, out_we}, 32'd0);
    chk("R11 error raised", {31'b0, acc_err}, 32'd1);
    clear_err();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_unlock_pass();
    t_bad_key();
    t_wrong_target();
    t_expiry();
    t_unprot();
    t_sticky();
    t_idle();
    t_rearm();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule